// File: doc/BRIEF.md
# Periodic Interval Timer with Wrap Counter

This block produces a periodic event from the system clock. A fixed divide-by-16 prescaler feeds an interval counter. The interval counter climbs from zero to a programmed limit and then returns to zero. Each return to zero is a wrap. Every wrap sets a sticky status flag and adds one to a 12-bit wrap counter, which saturates. The level interrupt output is the status flag gated by an interrupt enable. Software can let the counter run without taking interrupts and still measure elapsed time from the wrap counter and the live counter value.

Software reaches the block through a plain register bus with an address, a write strobe, a read strobe, write data and read data. The timer value can be read through two addresses that return the same word. Reading one of them acknowledges the pending wraps. Reading the other has no side effect, so a handler can consume events and a time-keeping routine can sample the counter without disturbing each other. The bus and the interrupt are control and status pins: they carry no valid/ready stream and exert no back-pressure. A strobe is accepted in the cycle it is high.

Top module: `interval_tick_timer`

## Requirements
- R1: While the timer is running, the interval counter advances by exactly one every 16 clock cycles and holds its value in all other cycles.
- R2: The mode register (address 0) holds the limit in bits 19:0. The counter counts 0,1,…,limit and then returns to 0, so one period is (limit+1)×16 clock cycles. A tick with the counter at or above the limit is a wrap.
- R3: Mode bit 24 is the timer enable and mode bit 25 is the interrupt enable. With bit 24 set and bit 25 clear, the counter runs and no interrupt is raised. With both set, `irq` equals the status flag.
- R4: A read strobe in cycle N puts the addressed word on `bus_rdata` in cycle N+1. The word reflects the state before the edge that ends cycle N. Without a read strobe, `bus_rdata` is zero. Addresses 2 and 3 return the counter in bits 19:0 and the wrap count in bits 31:20. Address 1 returns the status flag in bit 0. Unmapped addresses read as zero, and writes to them are ignored.
- R5: A read of address 2 clears the wrap count and the status flag.
- R6: A read of address 3 returns the same fields as address 2 and changes no state.
- R7: Every wrap sets the status flag, whether or not the interrupt is enabled.
- R8: When a mode write clears the enable, the counter still finishes its current period at the previous limit, then stays at zero. A mode write with the enable clear does not change the limit in use.
- R9: The wrap count saturates at 4095 and never rolls over.
- R10: If a wrap and a read of address 2 occur in the same cycle, the wrap count becomes 1 and the status flag stays set.
- R11: Reset clears the mode register, the counter, the prescaler, the wrap count and the status flag, so every readable register returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 1 | Level interrupt: status flag AND interrupt enable |

## Verification
The bench targets these corner cases, and states what a faulty design would do in each:

- **Wrap and acknowledge in the same cycle.** The bench schedules the acknowledging read onto the exact cycle of a wrap. A design that lets the clear win would lose that event and read back a count of 0 with the flag low.
- **Saturation.** With a zero limit the bench runs more than 4096 wraps. A counter that rolls over would report a small number instead of 4095.
- **Disable in mid-period.** The bench clears the enable partway through a period. A design that stops at once, or that picks up the zeroed limit, would either report no finishing wrap or wrap immediately.
- **Side effects by address.** The non-acknowledging read must leave the flag and the count unchanged, and acknowledge reads must not leak into them. A decode that mixes up the two value addresses would clear state on the wrong read.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  // Register word addresses; the value pair at 2/3 differ only in side effect
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_VACK = 2'd2,
    SEL_VIMG = 2'd3
  } reg_sel_e;

  // Offsets of the control bits above the limit field in the mode word
  localparam int EN_OFS  = 4;
  localparam int IEN_OFS = 5;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = run_i && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
    end else if (pre_q == LAST) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R1

endmodule

// File: rtl/ivt_interval.sv
module ivt_interval #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // At-or-above also covers a limit lowered below the running count
  assign wrap_o = tick_i && (cnt_q >= limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o)); // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_o == '0)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wrap_o) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R2

endmodule

// File: rtl/ivt_wrapcount.sv
module ivt_wrapcount #(
  parameter int WRAP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_i,
  input  logic              ack_i,
  output logic [WRAP_W-1:0] count_o,
  output logic              flag_o
);
  localparam logic [WRAP_W-1:0] TOP = '1;

  logic [WRAP_W-1:0] count_q;
  logic              flag_q;

  assign count_o = count_q;
  assign flag_o  = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (ack_i) begin
        count_q <= wrap_i ? WRAP_W'(1) : '0;
      end else if (wrap_i && (count_q != TOP)) begin
        count_q <= count_q + 1'b1;
      end
      if (wrap_i) begin
        flag_q <= 1'b1;
      end else if (ack_i) begin
        flag_q <= 1'b0;
      end
    end
  end

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_o); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !wrap_i) |=> (!flag_o && count_o == '0)); // R5
  AST_ACK_WITH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && wrap_i) |=> (flag_o && count_o == WRAP_W'(1))); // R10
  AST_NO_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == TOP && !ack_i) |=> (count_o == TOP)); // R9

endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
  parameter  int CNT_W   = 20,
  parameter  int WRAP_W  = 12,
  parameter  int ADDR_W  = 4,
  parameter  int PRE_DIV = 16,
  localparam int DATA_W  = CNT_W + WRAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import ivt_pkg::*;

  localparam int EN_BIT  = CNT_W + EN_OFS;
  localparam int IEN_BIT = CNT_W + IEN_OFS;

  logic [CNT_W-1:0]  limit_fld_q;  // readable limit field
  logic [CNT_W-1:0]  limit_use_q;  // limit the counter compares against
  logic              en_q;
  logic              ien_q;

  logic              run;
  logic              tick;
  logic              wrap;
  logic [CNT_W-1:0]  cnt;
  logic [WRAP_W-1:0] wrap_cnt;
  logic              flag;

  logic              hit_mode, hit_stat, hit_vack, hit_vimg;
  logic              wr_mode, ack;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              wdata_unused;

  assign hit_mode = (bus_addr == ADDR_W'(SEL_MODE));
  assign hit_stat = (bus_addr == ADDR_W'(SEL_STAT));
  assign hit_vack = (bus_addr == ADDR_W'(SEL_VACK));
  assign hit_vimg = (bus_addr == ADDR_W'(SEL_VIMG));

  assign wr_mode = bus_wr && hit_mode;
  assign ack     = bus_rd && hit_vack;

  assign wdata_unused = ^{bus_wdata[DATA_W-1:IEN_BIT+1], bus_wdata[EN_BIT-1:CNT_W]};

  // Mode register: a write that clears the enable keeps the limit in use
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_fld_q <= '0;
      limit_use_q <= '0;
      en_q        <= 1'b0;
      ien_q       <= 1'b0;
    end else if (wr_mode) begin
      limit_fld_q <= bus_wdata[CNT_W-1:0];
      en_q        <= bus_wdata[EN_BIT];
      ien_q       <= bus_wdata[IEN_BIT];
      if (bus_wdata[EN_BIT]) begin
        limit_use_q <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  // Keep running after disable until the period in progress completes
  assign run = en_q || (cnt != '0);

  ivt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  ivt_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .limit_i (limit_use_q),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  ivt_wrapcount #(.WRAP_W(WRAP_W)) u_wc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap_i  (wrap),
    .ack_i   (ack),
    .count_o (wrap_cnt),
    .flag_o  (flag)
  );

  always_comb begin
    rd_word = '0;
    if (hit_mode) begin
      rd_word[CNT_W-1:0] = limit_fld_q;
      rd_word[EN_BIT]    = en_q;
      rd_word[IEN_BIT]   = ien_q;
    end else if (hit_stat) begin
      rd_word[0] = flag;
    end else if (hit_vack || hit_vimg) begin
      rd_word = {wrap_cnt, cnt};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= bus_rd ? rd_word : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = flag && ien_q;

  AST_IDLE_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && cnt == '0 && !wr_mode) |=> (cnt == '0)); // R8
  AST_IMAGE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_vimg && !wrap) |=> ($stable(wrap_cnt) && $stable(flag))); // R6
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0)); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q && !wr_mode) |=> !irq); // R3

endmodule

// File: tb/sim_interval_tick_timer.sv
module sim_interval_tick_timer;
  localparam int DIV  = 16;
  localparam int CMAX = 4095;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  interval_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_pre, m_cnt, m_limit, m_lfld, m_wraps;
  bit m_en, m_ien, m_flag;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    logic [31:0] nrd;
    bit act, tk, wr;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_limit = 0; m_lfld = 0; m_wraps = 0;
      m_en = 0; m_ien = 0; m_flag = 0; m_rdata = 0;
    end else begin
      nrd = 0;
      if (bus_rd) begin
        case (bus_addr)
          4'd0: nrd = 32'(m_lfld) | (m_en ? 32'h0100_0000 : 0) | (m_ien ? 32'h0200_0000 : 0);
          4'd1: nrd = {31'd0, m_flag};
          4'd2, 4'd3: nrd = (32'(m_wraps) << 20) | 32'(m_cnt);
          default: nrd = 0;
        endcase
      end
      act = m_en || (m_cnt != 0);
      tk  = act && (m_pre == DIV - 1);
      wr  = tk && (m_cnt >= m_limit);
      m_pre = act ? (m_pre + 1) % DIV : 0;
      if (tk) m_cnt = wr ? 0 : m_cnt + 1;
      if (bus_rd && bus_addr == 4'd2) begin
        m_wraps = wr ? 1 : 0;
        m_flag  = wr ? 1'b1 : 1'b0;
      end else if (wr) begin
        if (m_wraps < CMAX) m_wraps++;
        m_flag = 1'b1;
      end
      if (bus_wr && bus_addr == 4'd0) begin
        m_lfld = int'(bus_wdata[19:0]);
        m_en   = bus_wdata[24];
        m_ien  = bus_wdata[25];
        if (bus_wdata[24]) m_limit = int'(bus_wdata[19:0]);
      end
      m_rdata = nrd;
    end
  end

  // Per-cycle comparison against the model
  always begin
    @(posedge clk);
    #1;
    checks++;
    if (bus_rdata !== m_rdata) begin
      errors++;
      $display("FAIL R1 R2 R4 per-cycle rdata: actual %h expected %h at %0t", bus_rdata, m_rdata, $time);
    end
    checks++;
    if (irq !== (m_flag && m_ien)) begin
      errors++;
      $display("FAIL R3 per-cycle irq: actual %b expected %b at %0t", irq, (m_flag && m_ien), $time);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int c1, c2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    bus_read(4'd0, v); check("R11 mode after reset", v, 32'h0);
    bus_read(4'd1, v); check("R11 status after reset", v, 32'h0);
    bus_read(4'd3, v); check("R11 value after reset", v, 32'h0);

    // R3/R7: run with limit 3, interrupt disabled
    bus_write(4'd0, 32'h0100_0003);
    idle(140);
    bus_read(4'd1, v); check("R7 flag set by wrap", v, 32'h1);
    check("R3 no irq while masked", {31'd0, irq}, 32'h0);
    bus_read(4'd3, v); check("R4 two wraps in wrap field", {20'd0, v[31:20]}, 32'd2);
    bus_read(4'd0, v); check("R2 R3 mode readback", v, 32'h0100_0003);

    // R1: one count step per 16 cycles
    bus_read(4'd3, v);
    c1 = int'(v[19:0]);
    idle(14);
    bus_read(4'd3, v);
    c2 = int'(v[19:0]);
    check("R1 step per 16 cycles", 32'((c2 - c1 + 4) % 4), 32'd1);

    // R6: image reads leave flag set
    bus_read(4'd3, v);
    bus_read(4'd3, v2);
    bus_read(4'd1, v); check("R6 flag kept after image reads", v, 32'h1);

    // R5: acknowledge well away from a wrap
    while (!(m_pre == 1)) @(negedge clk);
    bus_read(4'd2, v);
    bus_read(4'd1, v); check("R5 flag cleared by ack", v, 32'h0);
    bus_read(4'd3, v); check("R5 wrap field cleared by ack", {20'd0, v[31:20]}, 32'd0);

    // R4: unmapped address
    bus_write(4'd9, 32'hFFFF_FFFF);
    bus_read(4'd9, v); check("R4 unmapped read zero", v, 32'h0);
    bus_read(4'd0, v); check("R4 unmapped write ignored", v, 32'h0100_0003);

    // R3: interrupt enabled
    bus_write(4'd0, 32'h0300_0003);
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    check("R3 irq raised", {31'd0, irq}, 32'h1);
    while (!(m_pre == 1)) @(negedge clk);
    bus_read(4'd2, v);
    check("R3 irq dropped after ack", {31'd0, irq}, 32'h0);

    // R10: ack lands on a wrap cycle (limit 0: every tick wraps)
    bus_write(4'd0, 32'h0300_0000);
    idle(3);
    while (!((m_en || m_cnt != 0) && m_pre == DIV - 1)) @(negedge clk);
    bus_addr = 4'd2; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    bus_read(4'd1, v); check("R10 flag kept on collision", v, 32'h1);
    bus_read(4'd3, v); check("R10 count is one", {20'd0, v[31:20]}, 32'd1);

    // R9: saturation
    idle(4096 * DIV + 200);
    bus_read(4'd3, v); check("R9 saturated", {20'd0, v[31:20]}, 32'd4095);
    idle(100);
    bus_read(4'd3, v); check("R9 still saturated", {20'd0, v[31:20]}, 32'd4095);

    // R8: disable mid-period with limit 7
    bus_write(4'd0, 32'h0100_0007);
    while (!(m_cnt == 1 && m_pre == 1)) @(negedge clk);
    bus_read(4'd2, v);
    while (!(m_cnt == 2)) @(negedge clk);
    bus_write(4'd0, 32'h0);
    idle(40);
    bus_read(4'd3, v);
    check("R8 still counting after disable", {31'd0, (v[19:0] != 0)}, 32'h1);
    idle(160);
    bus_read(4'd3, v); check("R8 finishing wrap counted, counter at zero", v, 32'h0010_0000);
    idle(100);
    bus_read(4'd3, v); check("R8 stays at zero", v, 32'h0010_0000);

    idle(5);
    summary();
    $finish;
  end

endmodule